// File: doc/BRIEF.md
# Gated Capture Window and Period Timestamp Unit

This block decides when an acquisition is running and, for each capture period inside it, reports when the period was captured, when its first accepted sample arrived, and when its last accepted sample ended. Single-cycle arm and disarm strobes open and close the acquisition. The acquisition also closes when the level-sensitive enable input falls. While the acquisition runs, the level-sensitive gate input decides which clock ticks count as samples. An edge on the capture input closes the current period and starts the next one. The capture input can react to its rising edge, its falling edge or both.

A free-running 64-bit time counter is sampled to form three timestamps per period: the capture time, the period start and the period end. The block also reports how many gated ticks the period held. That count can be scaled down by a right shift of up to eight bits so that very long periods still fit a 32-bit word. Every 64-bit timestamp leaves the block as a low word and a high word. All result words are registered. They change only on the cycle that carries the capture pulse, or when a new arm clears them.

Top module: `gate_capture_timer`

## Requirements
- R1: `activeOut` is high from the first clock edge at which `armStb` is sampled high. When arm and disarm arrive together, arm wins.
- R2: A `disarmStb` sampled high without `armStb` drives `activeOut` low at that edge.
- R3: When `enableIn` was high at the previous edge and is low at this edge, `activeOut` goes low at this edge. A high enable level never arms the block by itself.
- R4: `edgeSel` encoding: 0 is rising, 1 is falling, 2 is both edges, 3 behaves as rising. The edge is judged against the `captureIn` value at the previous edge. A capture edge seen while `activeOut` is high makes `capPulse` high for exactly the following cycle.
- R5: `capTsLo`/`capTsHi` hold bits 31:0 and 63:32 of `tsNow` as sampled on the capture tick.
- R6: The sample count covers every tick in the period at which `gateIn` was high while active. This includes the capture tick itself. The next period starts counting on the tick after the capture, so back-to-back periods leave no gap.
- R7: `startTs*` is `tsNow` at the first gate-high tick of the period. `endTs*` is `tsNow`+1 at the last gate-high tick. Both are zero when the gate was never high in the period.
- R8: `sampleCount` is the period count shifted right by `shiftSel` bits, keeping the low 32 bits. Any `shiftSel` above 8 acts as 8.
- R9: While `activeOut` is low, gate and capture activity changes no output. The held results stay as they were.
- R10: An arm clears the period count, both period timestamps and all result words to zero.
- R11: After reset, `activeOut`, `capPulse` and every result word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| armStb | input | 1 | Single-cycle arm strobe |
| disarmStb | input | 1 | Single-cycle soft disarm strobe |
| enableIn | input | 1 | Level enable; its falling edge ends acquisition |
| gateIn | input | 1 | Level gate selecting sampled ticks |
| captureIn | input | 1 | Capture input, edge sensitive |
| edgeSel | input | 2 | Capture edge choice (0 rise, 1 fall, 2 both) |
| shiftSel | input | 4 | Right shift applied to the sample count |
| tsNow | input | 64 | Free-running time counter |
| activeOut | output | 1 | Acquisition running |
| capPulse | output | 1 | One-cycle pulse marking new results |
| capTsLo | output | 32 | Capture time, low word |
| capTsHi | output | 32 | Capture time, high word |
| startTsLo | output | 32 | Period start time, low word |
| startTsHi | output | 32 | Period start time, high word |
| endTsLo | output | 32 | Period end time, low word |
| endTsHi | output | 32 | Period end time, high word |
| sampleCount | output | 32 | Shifted gated-tick count |

## Verification
The directed patterns cover several cases. A sparse gate with rising captures separates start and end tracking from the capture time. A gate held high across toggled captures on both edges shows whether the capture tick is counted once and the periods join without a gap. Tying gate and capture together on the falling edge checks that a period ends on the tick after its last sample. An empty period shows the zero rule, and large shift settings show the clamp at eight. Random gate, capture, enable and strobe traffic then mixes arms, soft disarms and hard disarms. This exposes ordering faults between arming, sampling and capturing on the same tick. The time counter starts just below a 32-bit boundary so that the low and high words must split correctly.

// File: rtl/gcap_pkg.sv
package gcap_pkg;
  // capture edge selection codes
  localparam logic [1:0] EDGE_RISE = 2'd0;
  localparam logic [1:0] EDGE_FALL = 2'd1;
  localparam logic [1:0] EDGE_BOTH = 2'd2;

  // strobes from control to datapath, all for the current tick
  typedef struct packed {
    logic clear;     // new arm: wipe period and results
    logic sampleEn;  // gate high while active
    logic capEv;     // selected capture edge while active
  } gcapCtrl_t;
endpackage

// File: rtl/gcap_ctrl.sv
module gcap_ctrl
  import gcap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       armStb,
  input  logic       disarmStb,
  input  logic       enableIn,
  input  logic       gateIn,
  input  logic       captureIn,
  input  logic [1:0] edgeSel,
  output logic       activeOut,
  output gcapCtrl_t  ctrl
);
  logic activeQ;
  logic enPrev;
  logic capPrev;
  logic enFall;
  logic capRise;
  logic capFall;
  logic capHit;

  assign enFall  = enPrev & ~enableIn;
  assign capRise = captureIn & ~capPrev;
  assign capFall = ~captureIn & capPrev;

  always_comb begin
    case (edgeSel)
      EDGE_FALL: capHit = capFall;
      EDGE_BOTH: capHit = capRise | capFall;
      default:   capHit = capRise;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      enPrev  <= 1'b0;
      capPrev <= 1'b0;
    end else begin
      enPrev  <= enableIn;
      capPrev <= captureIn;
      if (armStb)
        activeQ <= 1'b1;
      else if (disarmStb || enFall)
        activeQ <= 1'b0;
    end
  end

  // sampling is judged on the state held before this edge
  assign ctrl.clear    = armStb;
  assign ctrl.sampleEn = activeQ & gateIn;
  assign ctrl.capEv    = activeQ & capHit;
  assign activeOut     = activeQ;
endmodule

// File: rtl/gcap_dpath.sv
module gcap_dpath
  import gcap_pkg::*;
#(
  parameter int TS_W      = 64,
  parameter int WORD_W    = 32,
  parameter int MAX_SHIFT = 8,
  parameter int SHIFT_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  gcapCtrl_t          ctrl,
  input  logic [SHIFT_W-1:0] shiftSel,
  input  logic [TS_W-1:0]    tsNow,
  output logic               capPulse,
  output logic [TS_W-1:0]    capTs,
  output logic [TS_W-1:0]    startTs,
  output logic [TS_W-1:0]    endTs,
  output logic [WORD_W-1:0]  sampleCount
);
  localparam int CNT_W = WORD_W + MAX_SHIFT;

  logic [CNT_W-1:0]   accCnt;
  logic               haveGate;
  logic [TS_W-1:0]    firstTs;
  logic [TS_W-1:0]    lastEndTs;

  logic [CNT_W-1:0]   cntNow;
  logic [TS_W-1:0]    startNow;
  logic [TS_W-1:0]    endNow;
  logic [SHIFT_W-1:0] shiftEff;
  logic [CNT_W-1:0]   cntShifted;

  assign cntNow   = accCnt + CNT_W'(ctrl.sampleEn);
  assign startNow = haveGate ? firstTs : (ctrl.sampleEn ? tsNow : '0);
  assign endNow   = ctrl.sampleEn ? tsNow + TS_W'(1) : lastEndTs;
  assign shiftEff = (shiftSel > SHIFT_W'(MAX_SHIFT)) ? SHIFT_W'(MAX_SHIFT) : shiftSel;
  assign cntShifted = cntNow >> shiftEff;

  // period accumulators
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accCnt    <= '0;
      haveGate  <= 1'b0;
      firstTs   <= '0;
      lastEndTs <= '0;
    end else if (ctrl.clear || ctrl.capEv) begin
      accCnt    <= '0;
      haveGate  <= 1'b0;
      firstTs   <= '0;
      lastEndTs <= '0;
    end else if (ctrl.sampleEn) begin
      accCnt    <= cntNow;
      lastEndTs <= endNow;
      if (!haveGate) begin
        haveGate <= 1'b1;
        firstTs  <= tsNow;
      end
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capPulse    <= 1'b0;
      capTs       <= '0;
      startTs     <= '0;
      endTs       <= '0;
      sampleCount <= '0;
    end else if (ctrl.clear) begin
      capPulse    <= 1'b0;
      capTs       <= '0;
      startTs     <= '0;
      endTs       <= '0;
      sampleCount <= '0;
    end else begin
      capPulse <= ctrl.capEv;
      if (ctrl.capEv) begin
        capTs       <= tsNow;
        startTs     <= startNow;
        endTs       <= endNow;
        sampleCount <= cntShifted[WORD_W-1:0];
      end
    end
  end
endmodule

// File: rtl/gate_capture_timer.sv
module gate_capture_timer
  import gcap_pkg::*;
#(
  parameter int TS_W      = 64,
  parameter int WORD_W    = 32,
  parameter int MAX_SHIFT = 8,
  parameter int SHIFT_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               armStb,
  input  logic               disarmStb,
  input  logic               enableIn,
  input  logic               gateIn,
  input  logic               captureIn,
  input  logic [1:0]         edgeSel,
  input  logic [SHIFT_W-1:0] shiftSel,
  input  logic [TS_W-1:0]    tsNow,
  output logic               activeOut,
  output logic               capPulse,
  output logic [WORD_W-1:0]  capTsLo,
  output logic [WORD_W-1:0]  capTsHi,
  output logic [WORD_W-1:0]  startTsLo,
  output logic [WORD_W-1:0]  startTsHi,
  output logic [WORD_W-1:0]  endTsLo,
  output logic [WORD_W-1:0]  endTsHi,
  output logic [WORD_W-1:0]  sampleCount
);
  localparam int N_TS = 3;

  gcapCtrl_t       ctrl;
  logic [TS_W-1:0] tsWide [N_TS];
  logic [WORD_W-1:0] tsLo [N_TS];
  logic [WORD_W-1:0] tsHi [N_TS];

  gcap_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .armStb    (armStb),
    .disarmStb (disarmStb),
    .enableIn  (enableIn),
    .gateIn    (gateIn),
    .captureIn (captureIn),
    .edgeSel   (edgeSel),
    .activeOut (activeOut),
    .ctrl      (ctrl)
  );

  gcap_dpath #(
    .TS_W      (TS_W),
    .WORD_W    (WORD_W),
    .MAX_SHIFT (MAX_SHIFT),
    .SHIFT_W   (SHIFT_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .shiftSel    (shiftSel),
    .tsNow       (tsNow),
    .capPulse    (capPulse),
    .capTs       (tsWide[0]),
    .startTs     (tsWide[1]),
    .endTs       (tsWide[2]),
    .sampleCount (sampleCount)
  );

  // split each timestamp into low and high words
  for (genvar i = 0; i < N_TS; i++) begin : g_split
    assign tsLo[i] = tsWide[i][WORD_W-1:0];
    assign tsHi[i] = tsWide[i][2*WORD_W-1:WORD_W];
  end

  assign capTsLo   = tsLo[0];
  assign capTsHi   = tsHi[0];
  assign startTsLo = tsLo[1];
  assign startTsHi = tsHi[1];
  assign endTsLo   = tsLo[2];
  assign endTsHi   = tsHi[2];
endmodule

// File: rtl/gcap_checker.sv
module gcap_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              armStb,
  input logic              disarmStb,
  input logic              enableIn,
  input logic              activeOut,
  input logic              capPulse,
  input logic [WORD_W-1:0] startTsLo,
  input logic [WORD_W-1:0] startTsHi,
  input logic [WORD_W-1:0] endTsLo,
  input logic [WORD_W-1:0] endTsHi,
  input logic [WORD_W-1:0] sampleCount
);
  p_arm_sets_active_r1: assert property (@(posedge clk) disable iff (!rstN)
    armStb |=> activeOut);

  p_soft_disarm_r2: assert property (@(posedge clk) disable iff (!rstN)
    (disarmStb && !armStb) |=> !activeOut);

  p_hard_disarm_r3: assert property (@(posedge clk) disable iff (!rstN)
    (activeOut && !armStb && $past(enableIn) && !enableIn) |=> !activeOut);

  p_pulse_after_active_r4: assert property (@(posedge clk) disable iff (!rstN)
    capPulse |-> $past(activeOut));

  p_start_before_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    (capPulse && ({endTsHi, endTsLo} != '0)) |->
      ({endTsHi, endTsLo} > {startTsHi, startTsLo}));

  p_hold_without_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!capPulse && !$past(armStb)) |-> ($stable(sampleCount) && $stable(endTsLo)));
endmodule

bind gate_capture_timer gcap_checker #(.WORD_W(WORD_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .armStb      (armStb),
  .disarmStb   (disarmStb),
  .enableIn    (enableIn),
  .activeOut   (activeOut),
  .capPulse    (capPulse),
  .startTsLo   (startTsLo),
  .startTsHi   (startTsHi),
  .endTsLo     (endTsLo),
  .endTsHi     (endTsHi),
  .sampleCount (sampleCount)
);

// File: tb/gate_capture_timer_tb_top.sv
`timescale 1ns/1ps
module gate_capture_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        armStb = 1'b0, disarmStb = 1'b0, enableIn = 1'b0;
  logic        gateIn = 1'b0, captureIn = 1'b0;
  logic [1:0]  edgeSel = 2'd0;
  logic [3:0]  shiftSel = 4'd0;
  logic [63:0] tsNow = 64'h0000_0000_FFFF_FFC0;
  logic        activeOut, capPulse;
  logic [31:0] capTsLo, capTsHi, startTsLo, startTsHi, endTsLo, endTsHi, sampleCount;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  gate_capture_timer dut_i (
    .clk(clk), .rstN(rstN), .armStb(armStb), .disarmStb(disarmStb),
    .enableIn(enableIn), .gateIn(gateIn), .captureIn(captureIn),
    .edgeSel(edgeSel), .shiftSel(shiftSel), .tsNow(tsNow),
    .activeOut(activeOut), .capPulse(capPulse),
    .capTsLo(capTsLo), .capTsHi(capTsHi), .startTsLo(startTsLo),
    .startTsHi(startTsHi), .endTsLo(endTsLo), .endTsHi(endTsHi),
    .sampleCount(sampleCount)
  );

  // reference state built from the requirements
  bit          mActive, mEnPrev, mCapPrev, mHave, mPulse;
  longint unsigned mCnt;
  logic [63:0] mFirst, mLastEnd, mCap, mStart, mEnd;
  logic [31:0] mCount;

  function automatic bit edgeHit(logic [1:0] sel, bit prev, bit cur);
    case (sel)
      2'd1:    return prev && !cur;
      2'd2:    return prev != cur;
      default: return !prev && cur;
    endcase
  endfunction

  function automatic logic [31:0] shiftCount(longint unsigned cnt, logic [3:0] sh);
    int s;
    s = (sh > 8) ? 8 : int'(sh);
    return 32'(cnt >> s);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0; mEnPrev = 0; mCapPrev = 0; mHave = 0; mPulse = 0; mCnt = 0;
      mFirst = '0; mLastEnd = '0; mCap = '0; mStart = '0; mEnd = '0; mCount = '0;
    end else begin
      bit g, c, enFall;
      longint unsigned cnt;
      logic [63:0] st, en;
      g = mActive && gateIn;
      c = mActive && edgeHit(edgeSel, mCapPrev, captureIn);
      enFall = mEnPrev && !enableIn;
      if (armStb) begin
        mCnt = 0; mHave = 0; mFirst = '0; mLastEnd = '0;
        mCap = '0; mStart = '0; mEnd = '0; mCount = '0; mPulse = 0;
      end else begin
        cnt = mCnt + (g ? 1 : 0);
        st = mHave ? mFirst : (g ? tsNow : 64'd0);
        en = g ? tsNow + 64'd1 : mLastEnd;
        mPulse = c;
        if (c) begin
          mCap = tsNow; mStart = st; mEnd = en; mCount = shiftCount(cnt, shiftSel);
          mCnt = 0; mHave = 0; mFirst = '0; mLastEnd = '0;
        end else if (g) begin
          mCnt = cnt; mLastEnd = en;
          if (!mHave) begin mHave = 1; mFirst = tsNow; end
        end
      end
      if (armStb) mActive = 1;
      else if (disarmStb || enFall) mActive = 0;
      mEnPrev = enableIn;
      mCapPrev = captureIn;
    end
  end

  always @(posedge clk) begin
    #1 tsNow = tsNow + 64'd1;
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every output against the reference away from the edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R1 R2 R3 activeOut", 64'(activeOut), 64'(mActive));
      chk("R4 capPulse", 64'(capPulse), 64'(mPulse));
      chk("R5 capTs", {capTsHi, capTsLo}, mCap);
      chk("R7 startTs", {startTsHi, startTsLo}, mStart);
      chk("R7 endTs", {endTsHi, endTsLo}, mEnd);
      chk("R6 R8 sampleCount", 64'(sampleCount), 64'(mCount));
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic arm();
    armStb = 1; cyc(); armStb = 0;
  endtask

  task automatic capTog();
    captureIn = ~captureIn; cyc();
  endtask

  initial begin : watchdog
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [63:0] holdCap;
    logic [31:0] holdCnt;
    void'($urandom(32'd1234));
    cyc(4);
    // R11: reset state
    chk("R11 reset activeOut", 64'(activeOut), 64'd0);
    chk("R11 reset capPulse", 64'(capPulse), 64'd0);
    chk("R11 reset words", {capTsLo, startTsLo, endTsLo, sampleCount} == '0 ? 64'd0 : 64'd1, 64'd0);
    rstN = 1; cyc(2);

    // R9: idle activity has no effect
    gateIn = 1; repeat (6) capTog(); gateIn = 0; cyc(2);
    chk("R9 idle count", 64'(sampleCount), 64'd0);
    chk("R9 idle capTs", {capTsHi, capTsLo}, 64'd0);

    // R1 R5 R6 R7: sparse gate, rising capture
    enableIn = 1; arm();
    chk("R1 active after arm", 64'(activeOut), 64'd1);
    cyc(2); gateIn = 1; cyc(3); gateIn = 0; cyc(2); gateIn = 1; cyc(); gateIn = 0; cyc(2);
    captureIn = 1; cyc();
    #1 chk("R6 sparse count", 64'(sampleCount), 64'd4);
    captureIn = 0; cyc(3);

    // R6: gap-less periods, gate held high, both edges
    edgeSel = 2'd2; gateIn = 1;
    repeat (5) begin cyc(3); capTog(); end
    gateIn = 0; cyc(2);

    // R7: gate and capture tied, falling edge
    edgeSel = 2'd1;
    repeat (3) begin gateIn = 1; captureIn = 1; cyc(4); gateIn = 0; captureIn = 0; cyc(3); end

    // R7: empty period reports zero
    edgeSel = 2'd0; cyc(3); captureIn = 1; cyc(); captureIn = 0; cyc();
    chk("R7 empty start", {startTsHi, startTsLo}, 64'd0);
    chk("R7 empty end", {endTsHi, endTsLo}, 64'd0);

    // R8: shift and clamp
    foreach (shiftSel[i]) ;
    shiftSel = 4'd3; gateIn = 1; cyc(40); captureIn = 1; cyc(); captureIn = 0; cyc();
    chk("R8 shift 3", 64'(sampleCount), 64'(41 >> 3));
    shiftSel = 4'd12; cyc(600); captureIn = 1; cyc(); captureIn = 0; cyc();
    chk("R8 shift clamp", 64'(sampleCount), 64'(602 >> 8));
    shiftSel = 4'd0; gateIn = 0;

    // R2 soft disarm, then R9 hold
    disarmStb = 1; cyc(); disarmStb = 0;
    chk("R2 soft disarm", 64'(activeOut), 64'd0);
    holdCap = {capTsHi, capTsLo}; holdCnt = sampleCount;
    gateIn = 1; repeat (4) capTog(); gateIn = 0; cyc(2);
    chk("R9 held capTs", {capTsHi, capTsLo}, holdCap);
    chk("R9 held count", 64'(sampleCount), 64'(holdCnt));

    // R10: arm clears results
    arm();
    chk("R10 cleared count", 64'(sampleCount), 64'd0);
    chk("R10 cleared capTs", {capTsHi, capTsLo}, 64'd0);

    // R3: hard disarm on enable fall
    cyc(2); enableIn = 0; cyc();
    chk("R3 hard disarm", 64'(activeOut), 64'd0);
    enableIn = 1; cyc(2);
    chk("R3 enable level does not arm", 64'(activeOut), 64'd0);

    // random traffic
    for (int k = 0; k < 6000; k++) begin
      if (k % 300 == 0) begin
        edgeSel = 2'($urandom_range(0, 3));
        shiftSel = 4'($urandom_range(0, 11));
      end
      gateIn = ($urandom_range(0, 9) < 6);
      if ($urandom_range(0, 3) == 0) captureIn = ~captureIn;
      armStb = ($urandom_range(0, 199) == 0);
      disarmStb = ($urandom_range(0, 399) == 0);
      enableIn = ($urandom_range(0, 249) != 0);
      cyc();
    end
    armStb = 0; disarmStb = 0; cyc(3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule